// File: doc/BRIEF.md
# DDR Write Burst Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface with 2n prefetch. It accepts write requests from a host through a valid/ready handshake. For each request it issues one WRITE command carrying a bank, a column and an auto-precharge flag. It then streams the write data as pairs of words per clock: one word for the rising half and one for the falling half, each with a per-byte mask. Around that data it frames the strobe with a low preamble and a low postamble.

A request may wait for the current burst to finish and follow it without a gap, which chains the two bursts. A request may also cut the current burst short on a pair boundary. In both cases the data stream stays continuous. After the last data pair, two countdowns hold off a READ and a PRECHARGE until the programmed write-to-read and write-recovery times have passed. The host uses `rd_allow` and `pre_allow` to decide when those commands may go out.

Top module: `ddr_wr_seq`

## Requirements
- R1: A request accepted at a clock edge (`req_valid` and `req_ready` both high) makes `cmd_wr` high for one cycle right after that edge. In that cycle `cmd_bank`, `cmd_col` and `cmd_ap` carry the request's bank, column and auto-precharge flag.
- R2: `cfg_bl` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives 16. A burst that is not cut short drives `dq_oe` high for exactly half that many consecutive cycles, starting the cycle after `cmd_wr`.
- R3: When a WRITE starts from idle, its command cycle is the preamble: `dqs_oe` is high and `dq_oe` is low, so the strobe is driven low.
- R4: The cycle after the last data cycle is the postamble: `dqs_oe` is high and `dq_oe` is low. In the cycle after that, `dqs_oe` is low.
- R5: Each data cycle shows, on `dq_rise`/`dq_fall`/`dm_rise`/`dm_fall`, the words taken from the data stream in the cycle before. The words are taken in order and not altered. A data-stream word is taken at a clock edge only when both `wd_ready` and `wd_valid` are high. If `wd_valid` is low at an edge where `wd_ready` is high, no word is taken: the next data cycle still goes out, with both masks all ones (every byte blocked).
- R6: A request with `req_cut` low is accepted only while idle or in the last data-transfer cycle of the current burst. A chained WRITE therefore follows the earlier one by exactly the earlier burst's pair count, and `dq_oe` stays high with no gap.
- R7: A request with `req_cut` high is accepted in any cycle. If it arrives x cycles after the earlier WRITE, the earlier burst keeps exactly x data pairs, and the new burst's data follows with no gap.
- R8: `rd_allow` is low from the WRITE command cycle onward. With write-to-read count N, it first goes high N cycles after the postamble cycle.
- R9: `pre_allow` behaves the same way as `rd_allow`, using the write-recovery count.
- R10: While no burst is active, `wd_ready` stays low, no data-stream word is taken, and `dq_oe` and `cmd_wr` stay low whatever the data stream presents.
- R11: After reset, `cmd_wr`, `dq_oe`, `dqs_oe` and `wd_ready` are low. `req_ready`, `rd_allow` and `pre_allow` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bl | input | 2 | Burst length code (2/4/8/16 beats) |
| cfg_wtr | input | TW | Write-to-read gap in cycles |
| cfg_wrec | input | TW | Write-recovery gap in cycles |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_cut | input | 1 | Request may truncate the current burst |
| req_bank | input | BA_W | Bank address |
| req_col | input | COL_W | Starting column |
| req_ap | input | 1 | Auto-precharge flag |
| wd_valid | input | 1 | Data pair available |
| wd_ready | output | 1 | Data pair taken at the next edge |
| wd_rise | input | DW | Rising-half data word |
| wd_fall | input | DW | Falling-half data word |
| wm_rise | input | DW/8 | Rising-half byte mask, 1 blocks the byte |
| wm_fall | input | DW/8 | Falling-half byte mask |
| cmd_wr | output | 1 | WRITE command strobe |
| cmd_bank | output | BA_W | WRITE bank |
| cmd_col | output | COL_W | WRITE column |
| cmd_ap | output | 1 | WRITE auto-precharge flag |
| dqs_oe | output | 1 | Strobe driven (low when dq_oe is low) |
| dq_oe | output | 1 | Data driven and strobe toggling this cycle |
| dq_rise | output | DW | Data for the rising strobe edge |
| dq_fall | output | DW | Data for the falling strobe edge |
| dm_rise | output | DW/8 | Mask for the rising edge |
| dm_fall | output | DW/8 | Mask for the falling edge |
| rd_allow | output | 1 | A READ may be issued |
| pre_allow | output | 1 | A PRECHARGE may be issued |

## Verification
The bench runs single bursts at every burst length and checks the exact cycles of preamble, data and postamble. A design that counted beats instead of pairs would keep `dq_oe` high twice as long, and one that omitted the framing would leave `dqs_oe` low around the data. It chains two requests and cuts one short after one and after two cycles. A design that accepted a chained request too early would truncate the first burst, and one that let a cut through only on burst end would keep the full burst. It starves the data stream in mid-burst, where a wrong design would drive unmasked stale bytes. It also counts the write-to-read and recovery gaps to the exact cycle, because an off-by-one there lets a READ or PRECHARGE out early.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    BL_2  = 2'd0,
    BL_4  = 2'd1,
    BL_8  = 2'd2,
    BL_16 = 2'd3
  } bl_code_t;

  // clock cycles of data (beat pairs) for a burst-length code
  function automatic logic [CNT_W-1:0] bl_pairs(input logic [1:0] code);
    return CNT_W'(1) << code;
  endfunction

endpackage

// File: rtl/ddr_wr_cmd.sv
module ddr_wr_cmd
  import ddr_wr_pkg::*;
#(
  parameter int BA_W  = 3,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_bl,
  input  logic             req_valid,
  input  logic             req_cut,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_ap,
  output logic             req_ready,
  output logic             launch,
  output logic             xfer,
  output logic             cmd_wr,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [COL_W-1:0] cmd_col,
  output logic             cmd_ap
);

  // pairs still to be taken from the data stream, current cycle included
  logic [CNT_W-1:0] pairs_left;

  assign req_ready = (pairs_left <= CNT_W'(1)) || req_cut;
  assign launch    = req_valid && req_ready;
  assign xfer      = (pairs_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pairs_left <= '0;
      cmd_wr     <= 1'b0;
      cmd_bank   <= '0;
      cmd_col    <= '0;
      cmd_ap     <= 1'b0;
    end else begin
      cmd_wr <= launch;
      if (launch) begin
        cmd_bank   <= req_bank;
        cmd_col    <= req_col;
        cmd_ap     <= req_ap;
        pairs_left <= bl_pairs(cfg_bl);
      end else if (xfer) begin
        pairs_left <= pairs_left - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/ddr_wr_data.sv
module ddr_wr_data #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          xfer,
  input  logic          wd_valid,
  input  logic [DW-1:0] wd_rise,
  input  logic [DW-1:0] wd_fall,
  input  logic [NB-1:0] wm_rise,
  input  logic [NB-1:0] wm_fall,
  output logic          burst_end,
  output logic          dqs_oe,
  output logic          dq_oe,
  output logic [DW-1:0] dq_rise,
  output logic [DW-1:0] dq_fall,
  output logic [NB-1:0] dm_rise,
  output logic [NB-1:0] dm_fall
);

  // last data cycle is on the pins and nothing follows it
  assign burst_end = dq_oe && !xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe   <= 1'b0;
      dqs_oe  <= 1'b0;
      dq_rise <= '0;
      dq_fall <= '0;
      dm_rise <= '1;
      dm_fall <= '1;
    end else begin
      dq_oe  <= xfer;
      // preamble on launch, held through data, postamble after last pair
      dqs_oe <= launch || xfer || dq_oe;
      if (xfer && wd_valid) begin
        dq_rise <= wd_rise;
        dq_fall <= wd_fall;
        dm_rise <= wm_rise;
        dm_fall <= wm_fall;
      end else begin
        dq_rise <= '0;
        dq_fall <= '0;
        dm_rise <= '1;
        dm_fall <= '1;
      end
    end
  end

  AST_GAP_MASKED: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wd_valid) |=> (dm_rise == '1 && dm_fall == '1)); // R5

endmodule

// File: rtl/ddr_wr_gap.sv
module ddr_wr_gap #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          busy,
  input  logic [TW-1:0] limit,
  output logic          allow
);

  logic [TW-1:0] left;

  assign allow = !busy && (left == '0);

  always_ff @(posedge clk) begin
    if (rst)
      left <= '0;
    else if (start)
      left <= limit;
    else if (left != '0)
      left <= left - TW'(1);
  end

endmodule

// File: rtl/ddr_wr_seq.sv
module ddr_wr_seq #(
  parameter int BA_W  = 3,
  parameter int COL_W = 10,
  parameter int DW    = 32,
  parameter int TW    = 4,
  localparam int NB   = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_bl,
  input  logic [TW-1:0]    cfg_wtr,
  input  logic [TW-1:0]    cfg_wrec,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_cut,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_ap,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [DW-1:0]    wd_rise,
  input  logic [DW-1:0]    wd_fall,
  input  logic [NB-1:0]    wm_rise,
  input  logic [NB-1:0]    wm_fall,
  output logic             cmd_wr,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [COL_W-1:0] cmd_col,
  output logic             cmd_ap,
  output logic             dqs_oe,
  output logic             dq_oe,
  output logic [DW-1:0]    dq_rise,
  output logic [DW-1:0]    dq_fall,
  output logic [NB-1:0]    dm_rise,
  output logic [NB-1:0]    dm_fall,
  output logic             rd_allow,
  output logic             pre_allow
);

  localparam int NGAP = 2;

  logic launch, xfer, burst_end, busy;
  logic [TW-1:0] gap_lim [NGAP];
  logic          gap_ok  [NGAP];

  assign wd_ready   = xfer;
  assign busy       = xfer || dq_oe;
  assign gap_lim[0] = cfg_wtr;
  assign gap_lim[1] = cfg_wrec;
  assign rd_allow   = gap_ok[0];
  assign pre_allow  = gap_ok[1];

  ddr_wr_cmd #(.BA_W(BA_W), .COL_W(COL_W)) u_cmd (
    .clk(clk), .rst(rst), .cfg_bl(cfg_bl),
    .req_valid(req_valid), .req_cut(req_cut), .req_bank(req_bank),
    .req_col(req_col), .req_ap(req_ap), .req_ready(req_ready),
    .launch(launch), .xfer(xfer), .cmd_wr(cmd_wr),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap)
  );

  ddr_wr_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .launch(launch), .xfer(xfer),
    .wd_valid(wd_valid), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .wm_rise(wm_rise), .wm_fall(wm_fall), .burst_end(burst_end),
    .dqs_oe(dqs_oe), .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dm_rise(dm_rise), .dm_fall(dm_fall)
  );

  for (genvar g = 0; g < NGAP; g++) begin : g_gap
    ddr_wr_gap #(.TW(TW)) u_gap (
      .clk(clk), .rst(rst), .start(burst_end), .busy(busy),
      .limit(gap_lim[g]), .allow(gap_ok[g])
    );
  end

  AST_DATA_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> dq_oe); // R2
  AST_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !dq_oe) |-> dqs_oe); // R3
  AST_POSTAMBLE: assert property (@(posedge clk) disable iff (rst)
    (!dq_oe && $past(dq_oe)) |-> dqs_oe); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_allow |-> (!dq_oe && !cmd_wr)); // R8
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    pre_allow |-> (!dq_oe && !cmd_wr)); // R9

endmodule

// File: tb/ddr_wr_seq_test.sv
`timescale 1ns/100ps
module ddr_wr_seq_test;

  localparam int BA_W = 3, COL_W = 10, DW = 32, TW = 4, NB = DW / 8;
  localparam int LN = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cfg_bl = 2'd1;
  logic [TW-1:0] cfg_wtr = '0, cfg_wrec = '0;
  logic req_valid = 1'b0, req_cut = 1'b0, req_ap = 1'b0;
  logic [BA_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic wd_valid = 1'b1;
  logic [15:0] seq;
  logic [DW-1:0] wd_rise, wd_fall;
  logic [NB-1:0] wm_rise, wm_fall;
  logic req_ready, wd_ready, cmd_wr, cmd_ap, dqs_oe, dq_oe, rd_allow, pre_allow;
  logic [BA_W-1:0] cmd_bank;
  logic [COL_W-1:0] cmd_col;
  logic [DW-1:0] dq_rise, dq_fall;
  logic [NB-1:0] dm_rise, dm_fall;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign wd_rise = {16'hA5A5, seq};
  assign wd_fall = {16'h5A5A, seq};
  assign wm_rise = seq[3:0];
  assign wm_fall = ~seq[3:0];

  always @(posedge clk)
    if (rst) seq <= '0;
    else if (wd_ready && wd_valid) seq <= seq + 16'd1;

  ddr_wr_seq #(.BA_W(BA_W), .COL_W(COL_W), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst(rst), .cfg_bl(cfg_bl), .cfg_wtr(cfg_wtr), .cfg_wrec(cfg_wrec),
    .req_valid(req_valid), .req_ready(req_ready), .req_cut(req_cut),
    .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .wm_rise(wm_rise), .wm_fall(wm_fall), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .dqs_oe(dqs_oe), .dq_oe(dq_oe),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .rd_allow(rd_allow), .pre_allow(pre_allow)
  );

  // per-cycle log of outputs, sampled 1 ns after each rising edge
  bit log_on = 1'b0;
  int li = 0;
  logic lg_cmd [LN], lg_dqoe [LN], lg_dqsoe [LN], lg_rd [LN], lg_pre [LN], lg_ap [LN];
  logic [COL_W-1:0] lg_col [LN];
  logic [BA_W-1:0] lg_bank [LN];
  logic [DW-1:0] lg_dq [LN], lg_dqf [LN];
  logic [NB-1:0] lg_dm [LN];

  always @(posedge clk) begin
    #1;
    if (log_on && li < LN) begin
      lg_cmd[li] = cmd_wr;   lg_dqoe[li] = dq_oe;  lg_dqsoe[li] = dqs_oe;
      lg_rd[li] = rd_allow;  lg_pre[li] = pre_allow; lg_ap[li] = cmd_ap;
      lg_col[li] = cmd_col;  lg_bank[li] = cmd_bank;
      lg_dq[li] = dq_rise;   lg_dqf[li] = dq_fall;  lg_dm[li] = dm_rise;
      li++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic start_log(output logic [15:0] s0);
    @(negedge clk);
    li = 0;
    s0 = seq;
    log_on = 1'b1;
  endtask

  task automatic run_idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    log_on = 1'b0;
  endtask

  // called at a falling edge, returns at a falling edge with the request taken
  task automatic issue(input logic [BA_W-1:0] b, input logic [COL_W-1:0] c,
                       input logic ap, input logic cut);
    req_bank = b; req_col = c; req_ap = ap; req_cut = cut; req_valid = 1'b1;
    forever begin
      #0.5;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0; req_cut = 1'b0;
  endtask

  function automatic int find_cmd(input int from);
    for (int i = from; i < li; i++) if (lg_cmd[i]) return i;
    return -1;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmd_wr && !dq_oe && !dqs_oe && !wd_ready, "R11 outputs idle", {cmd_wr, dq_oe, dqs_oe, wd_ready}, 0);
    chk(req_ready && rd_allow && pre_allow, "R11 ready/allow high", {req_ready, rd_allow, pre_allow}, 3'b111);
  endtask

  task automatic t_single(input logic [1:0] bl, input logic [BA_W-1:0] b,
                          input logic [COL_W-1:0] c, input logic ap,
                          input int wtr, input int wrec);
    logic [15:0] s0;
    int c0, p;
    cfg_bl = bl; cfg_wtr = TW'(wtr); cfg_wrec = TW'(wrec);
    p = 1 << bl;
    start_log(s0);
    issue(b, c, ap, 1'b0);
    run_idle(40);
    c0 = find_cmd(0);
    chk(c0 >= 0, "R1 command issued", c0, 0);
    if (c0 < 0) return;
    chk(lg_bank[c0] == b && lg_col[c0] == c && lg_ap[c0] == ap, "R1 command fields",
        {lg_bank[c0], lg_col[c0], lg_ap[c0]}, {b, c, ap});
    chk(!lg_cmd[c0 + 1], "R1 single-cycle command", lg_cmd[c0 + 1], 0);
    chk(lg_dqsoe[c0] && !lg_dqoe[c0], "R3 preamble", {lg_dqsoe[c0], lg_dqoe[c0]}, 2'b10);
    for (int k = 1; k <= p; k++) begin
      chk(lg_dqoe[c0 + k], "R2 data cycle", k, p);
      chk(lg_dq[c0 + k] == {16'hA5A5, 16'(s0 + 16'(k - 1))} &&
          lg_dm[c0 + k] == 4'(s0 + 16'(k - 1)), "R5 data order",
          lg_dq[c0 + k], {16'hA5A5, 16'(s0 + 16'(k - 1))});
    end
    chk(lg_dqf[c0 + 1] == {16'h5A5A, s0}, "R5 falling word", lg_dqf[c0 + 1], {16'h5A5A, s0});
    chk(!lg_dqoe[c0 + p + 1], "R2 burst length", lg_dqoe[c0 + p + 1], 0);
    chk(lg_dqsoe[c0 + p + 1] && !lg_dqsoe[c0 + p + 2], "R4 postamble",
        {lg_dqsoe[c0 + p + 1], lg_dqsoe[c0 + p + 2]}, 2'b10);
    chk(!lg_rd[c0] && !lg_rd[c0 + p + wtr] && lg_rd[c0 + p + 1 + wtr], "R8 write-to-read",
        {lg_rd[c0], lg_rd[c0 + p + wtr], lg_rd[c0 + p + 1 + wtr]}, 3'b001);
    chk(!lg_pre[c0] && !lg_pre[c0 + p + wrec] && lg_pre[c0 + p + 1 + wrec], "R9 write recovery",
        {lg_pre[c0], lg_pre[c0 + p + wrec], lg_pre[c0 + p + 1 + wrec]}, 3'b001);
  endtask

  task automatic t_chain();
    logic [15:0] s0;
    int c0, c1, n;
    cfg_bl = 2'd1; cfg_wtr = '0; cfg_wrec = '0;
    start_log(s0);
    issue(3'd1, 10'h010, 1'b0, 1'b0);
    issue(3'd2, 10'h020, 1'b0, 1'b0);
    run_idle(30);
    c0 = find_cmd(0);
    c1 = (c0 >= 0) ? find_cmd(c0 + 1) : -1;
    chk(c0 >= 0 && c1 == c0 + 2, "R6 chained command spacing", c1 - c0, 2);
    n = 0;
    for (int i = 0; i < li; i++) if (lg_dqoe[i]) n++;
    chk(n == 4 && c0 >= 0 && lg_dqoe[c0 + 1] && lg_dqoe[c0 + 4], "R6 continuous data", n, 4);
    if (c1 >= 0) chk(lg_col[c1] == 10'h020, "R6 second column", lg_col[c1], 10'h020);
  endtask

  task automatic t_cut(input int x);
    logic [15:0] s0;
    int c0, c1, n, first, last;
    cfg_bl = 2'd2; cfg_wtr = '0; cfg_wrec = '0;
    start_log(s0);
    issue(3'd3, 10'h100, 1'b0, 1'b0);
    for (int i = 1; i < x; i++) @(negedge clk);
    issue(3'd4, 10'h200, 1'b1, 1'b1);
    run_idle(30);
    c0 = find_cmd(0);
    c1 = (c0 >= 0) ? find_cmd(c0 + 1) : -1;
    chk(c0 >= 0 && c1 == c0 + x, "R7 cut command spacing", c1 - c0, x);
    n = 0; first = -1; last = -1;
    for (int i = 0; i < li; i++) if (lg_dqoe[i]) begin
      n++;
      if (first < 0) first = i;
      last = i;
    end
    chk(n == x + 4 && (last - first + 1) == n, "R7 kept pairs and no gap", n, x + 4);
    if (c1 >= 0) chk(lg_ap[c1] && lg_col[c1] == 10'h200, "R1 cut command fields",
                     {lg_ap[c1], lg_col[c1]}, {1'b1, 10'h200});
  endtask

  task automatic t_starve();
    logic [15:0] s0;
    int c0;
    bit allm;
    cfg_bl = 2'd2;
    wd_valid = 1'b0;
    start_log(s0);
    issue(3'd0, 10'h004, 1'b0, 1'b0);
    run_idle(20);
    wd_valid = 1'b1;
    c0 = find_cmd(0);
    allm = (c0 >= 0);
    for (int k = 1; k <= 4; k++) if (c0 >= 0 && (!lg_dqoe[c0 + k] || lg_dm[c0 + k] != 4'hF)) allm = 1'b0;
    chk(allm, "R5 starved beats masked", allm, 1);
    chk(seq == s0, "R5 no word taken when starved", seq, s0);
  endtask

  task automatic t_idle_ignore();
    logic [15:0] s0;
    bit quiet;
    start_log(s0);
    wd_valid = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wd_ready || dq_oe || cmd_wr) quiet = 1'b0;
    end
    log_on = 1'b0;
    chk(quiet, "R10 idle outputs quiet", quiet, 1);
    chk(seq == s0, "R10 idle data ignored", seq, s0);
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_single(2'd0, 3'd5, 10'h155, 1'b1, 2, 5);
    t_single(2'd1, 3'd2, 10'h0AA, 1'b0, 0, 3);
    t_single(2'd2, 3'd7, 10'h3F0, 1'b0, 4, 1);
    t_single(2'd3, 3'd1, 10'h001, 1'b1, 15, 15);
    t_chain();
    t_cut(1);
    t_cut(2);
    t_starve();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule